// File: doc/BRIEF.md
# Two-Register Nonlinear Word Mixer

This block is the nonlinear stage of a word-oriented keystream generator. It holds two 32-bit memory words, called A and B here. Each cycle it takes three 32-bit input words, X0, X1 and X2, and produces a 32-bit mixed output word. The output is combinational: it depends on the inputs and on the memory words currently held.

When the update enable is high at a clock edge, both memory words are replaced. The intermediate words are formed with a modular add and an XOR. Their half-words are swapped crosswise. Each result then passes through its own five-term rotate-XOR diffusion. Finally it goes through a 32-bit substitution made of four byte lanes that alternate between two fixed 8-bit tables.

A synchronous clear zeroes both memory words, as does the synchronous reset. The surrounding controller supplies the input words and decides when to update or clear.

Top module: `mixf_core`

## Requirements
- R1: `w_out` equals `(x0 XOR mem_a) + mem_b` modulo 2^32 at all times, with no register in that path.
- R2: At a clock edge with `upd`=1, `clr`=0 and `rst`=0, `mem_a` becomes `S(L1({low16(mem_a+x1), high16(mem_b XOR x2)}))`. Here L1(v) = v ^ rotl(v,2) ^ rotl(v,10) ^ rotl(v,18) ^ rotl(v,24).
- R3: At the same edge, `mem_b` becomes `S(L2({low16(mem_b XOR x2), high16(mem_a+x1)}))`. Here L2(v) = v ^ rotl(v,8) ^ rotl(v,14) ^ rotl(v,22) ^ rotl(v,30).
- R4: At an edge with `upd`=0, `clr`=0 and `rst`=0, both memory words keep their values, whatever the input words are.
- R5: At an edge with `clr`=1, both memory words become zero, even when `upd`=1 in the same cycle.
- R6: At an edge with `rst`=1, both memory words become zero.
- R7: S maps bits 31:24 through table T0, bits 23:16 through T1, bits 15:8 through T0 and bits 7:0 through T1. Each table is indexed with the high nibble selecting the row and the low nibble selecting the column. Known values: T0(0x12)=0xF9, T1(0x34)=0xC0, S(0x12345678)=0xF9C05A4E and S(0)=0x3E553E55.
- R8: In a cycle where an update takes place, `w_out` is computed from the memory words held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, zeroes both memory words |
| clr | input | 1 | Synchronous clear of both memory words, overrides `upd` |
| upd | input | 1 | Replace both memory words at this edge |
| x0 | input | 32 | Input word mixed into the output |
| x1 | input | 32 | Input word added to memory word A |
| x2 | input | 32 | Input word XORed into memory word B |
| w_out | output | 32 | Combinational mixed output word |
| mem_a | output | 32 | Memory word A |
| mem_b | output | 32 | Memory word B |

## Verification
Two functions can fall in the same cycle: the memory update and the clear. They are provoked together by raising `upd` and `clr` on the same cycle after the memory words hold nonzero values. The result is judged by expecting zero in both words one edge later, not the substituted values. A second overlap is a cycle that both reads `w_out` and updates the memory words. Here the bench expects the output computed from the old memory words, and expects the new words only after the edge.

// File: rtl/mixf_pkg.sv
package mixf_pkg;

  localparam int unsigned WORD = 32;
  localparam int unsigned BYTE = 8;

  // Each row packs 16 byte entries; column 0 sits in the top byte.
  localparam logic [127:0] T0_ROWS [16] = '{
    128'h3E725B47CAE0003304D1549809B96DCB,
    128'h7B1BF932AF9D6AA5B82DFC1D08530390,
    128'h4D4E8499E4CED991DDB685488B296EAC,
    128'hCDC1F81E734369C6B5BDFD396320D438,
    128'h767DB2A7CFED57C5F32CBB142106559B,
    128'hE3EF5E314F7F5AA40D8251495FBA581C,
    128'h4A16D517A892241F8CFFD8AE2E01D3AD,
    128'h3B4BDA46EBC9DE9A8F87D73A806F2FC8,
    128'hB1B437F70A2213287CCC3C89C7C39656,
    128'h07BF7EF00B2B975235417961A64C10FE,
    128'hBC2695888AB0A3FBC01894F2E1E5E95D,
    128'hD0DC1166645CEC59427512F5749CAA23,
    128'h0E86ABBE2A02E767E644A26CC2939FF1,
    128'hF6FA36D250689E6271153DD640C4E20F,
    128'h8E83776B25053F0C30EA70B7A1E8A965,
    128'h8D271ADB81B3A0F4457A19DFEE783460
  };

  localparam logic [127:0] T1_ROWS [16] = '{
    128'h55C263713BC847869F3CDA5B29AAFD77,
    128'h8CC5940CA61A1300E3A8167240F9F842,
    128'h4426689681D9453E1076C6A78B3943E1,
    128'h3AB5562AC06DB3052266BFDC0BFA6248,
    128'hDD20110636C9C1CFF62752BB69F5D487,
    128'h7F844CD29C57A4BC4F9ADFFED68D7AEB,
    128'h2B53D85CA11417FB23D57D3067730809,
    128'hEEB7703F61B2198E4EE54B938F5DDBA9,
    128'hADF1AE2ECB0DFCF42D466E1D97E8D1E9,
    128'h4D37A5755E839EAB829DB91CE0CD4989,
    128'h01B6BD5824A25F387899159050B895E4,
    128'hD091C7CEED0FB46FA0CCF0024A79C3DE,
    128'hA3EFEA51E66B18EC1B2C80F774E7FF21,
    128'h5A6A541E41319235C433070ABA7E0E34,
    128'h88B1987CF33D606C7BCAD31F32650428,
    128'h64BE859B2F598AD7B025ACAF1203E2F2
  };

  function automatic logic [7:0] pick_byte(input logic [127:0] row, input logic [3:0] col);
    logic [127:0] sh;
    sh = row >> (BYTE * (15 - int'(col)));
    return sh[7:0];
  endfunction

  function automatic logic [7:0] lut_t0(input logic [7:0] b);
    return pick_byte(T0_ROWS[b[7:4]], b[3:0]);
  endfunction

  function automatic logic [7:0] lut_t1(input logic [7:0] b);
    return pick_byte(T1_ROWS[b[7:4]], b[3:0]);
  endfunction

endpackage

// File: rtl/mixf_diffuse.sv
module mixf_diffuse #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned TAP_A  = 2,
  parameter int unsigned TAP_B  = 10,
  parameter int unsigned TAP_C  = 18,
  parameter int unsigned TAP_D  = 24
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int unsigned NTAP = 4;
  localparam int unsigned TAPS [NTAP] = '{TAP_A, TAP_B, TAP_C, TAP_D};

  logic [WORD_W-1:0] rot [NTAP];

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign rot[t] = {din[WORD_W-1-TAPS[t]:0], din[WORD_W-1:WORD_W-TAPS[t]]};
  end

  always_comb begin
    dout = din;
    for (int t = 0; t < NTAP; t++) begin
      dout = dout ^ rot[t];
    end
  end
endmodule

// File: rtl/mixf_sbox.sv
module mixf_sbox #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  import mixf_pkg::*;
  localparam int unsigned LANES = WORD_W / BYTE;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    localparam int unsigned HI = WORD_W - 1 - BYTE * ln;
    if (ln % 2 == 0) begin : g_even
      assign dout[HI -: BYTE] = lut_t0(din[HI -: BYTE]);
    end else begin : g_odd
      assign dout[HI -: BYTE] = lut_t1(din[HI -: BYTE]);
    end
  end
endmodule

// File: rtl/mixf_state.sv
module mixf_state #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [WORD_W-1:0] nxt_a,
  input  logic [WORD_W-1:0] nxt_b,
  output logic [WORD_W-1:0] q_a,
  output logic [WORD_W-1:0] q_b
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_a <= '0;
      q_b <= '0;
    end else if (upd) begin
      q_a <= nxt_a;
      q_b <= nxt_b;
    end
  end
endmodule

// File: rtl/mixf_core.sv
module mixf_core #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [WORD_W-1:0] x0,
  input  logic [WORD_W-1:0] x1,
  input  logic [WORD_W-1:0] x2,
  output logic [WORD_W-1:0] w_out,
  output logic [WORD_W-1:0] mem_a,
  output logic [WORD_W-1:0] mem_b
);
  localparam int unsigned HALF = WORD_W / 2;

  logic [WORD_W-1:0] sum_a, mix_b;
  logic [WORD_W-1:0] swap_a, swap_b;
  logic [WORD_W-1:0] dif_a, dif_b;
  logic [WORD_W-1:0] sub_a, sub_b;

  // Output path: no register (R1, R8)
  assign w_out = (x0 ^ mem_a) + mem_b;

  assign sum_a  = mem_a + x1;
  assign mix_b  = mem_b ^ x2;
  assign swap_a = {sum_a[HALF-1:0], mix_b[WORD_W-1:HALF]};
  assign swap_b = {mix_b[HALF-1:0], sum_a[WORD_W-1:HALF]};

  mixf_diffuse #(.WORD_W(WORD_W), .TAP_A(2), .TAP_B(10), .TAP_C(18), .TAP_D(24))
    u_dif_a (.din(swap_a), .dout(dif_a));

  mixf_diffuse #(.WORD_W(WORD_W), .TAP_A(8), .TAP_B(14), .TAP_C(22), .TAP_D(30))
    u_dif_b (.din(swap_b), .dout(dif_b));

  mixf_sbox #(.WORD_W(WORD_W)) u_sub_a (.din(dif_a), .dout(sub_a));
  mixf_sbox #(.WORD_W(WORD_W)) u_sub_b (.din(dif_b), .dout(sub_b));

  mixf_state #(.WORD_W(WORD_W)) u_state (
    .clk(clk), .rst(rst), .clr(clr), .upd(upd),
    .nxt_a(sub_a), .nxt_b(sub_b),
    .q_a(mem_a), .q_b(mem_b)
  );
endmodule

// File: rtl/mixf_chk.sv
module mixf_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              upd,
  input logic [WORD_W-1:0] x0,
  input logic [WORD_W-1:0] x1,
  input logic [WORD_W-1:0] x2,
  input logic [WORD_W-1:0] w_out,
  input logic [WORD_W-1:0] mem_a,
  input logic [WORD_W-1:0] mem_b
);
  localparam logic [WORD_W-1:0] SUB_ZERO = 32'h3E553E55;

  assert_out_zero_mem_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_a == '0 && mem_b == '0) |-> (w_out == x0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !upd) |=> ($stable(mem_a) && $stable(mem_b)));

  assert_clear_prio_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mem_a == '0 && mem_b == '0));

  assert_reset_R6: assert property (@(posedge clk)
    rst |=> (mem_a == '0 && mem_b == '0));

  assert_zero_sub_R7: assert property (@(posedge clk) disable iff (rst)
    (upd && !clr && mem_a == '0 && mem_b == '0 && x1 == '0 && x2 == '0)
      |=> (mem_a == SUB_ZERO && mem_b == SUB_ZERO));
endmodule

bind mixf_core mixf_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .upd(upd),
  .x0(x0), .x1(x1), .x2(x2),
  .w_out(w_out), .mem_a(mem_a), .mem_b(mem_b)
);

// File: tb/tb_mixf_core.sv
`timescale 1ns/100ps
module tb_mixf_core;
  import mixf_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, upd = 1'b0;
  logic [31:0] x0 = '0, x1 = '0, x2 = '0;
  logic [31:0] w_out, mem_a, mem_b;

  always #2.5 clk = ~clk;

  mixf_core dut (.clk(clk), .rst(rst), .clr(clr), .upd(upd),
                 .x0(x0), .x1(x1), .x2(x2),
                 .w_out(w_out), .mem_a(mem_a), .mem_b(mem_b));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_a = '0, m_b = '0;
  logic [31:0] seed = 32'h1F2E3D4C;

  // scoreboard: {check_w, exp_w, exp_a, exp_b}
  logic [96:0] sb_q [$];
  string       tag_q [$];

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction
  function automatic logic [31:0] lin1(input logic [31:0] v);
    return v ^ rl(v, 2) ^ rl(v, 10) ^ rl(v, 18) ^ rl(v, 24);
  endfunction
  function automatic logic [31:0] lin2(input logic [31:0] v);
    return v ^ rl(v, 8) ^ rl(v, 14) ^ rl(v, 22) ^ rl(v, 30);
  endfunction
  function automatic logic [31:0] sub32(input logic [31:0] v);
    return {lut_t0(v[31:24]), lut_t1(v[23:16]), lut_t0(v[15:8]), lut_t1(v[7:0])};
  endfunction
  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic u,
                       input logic [31:0] a0, input logic [31:0] a1,
                       input logic [31:0] a2, input string req);
    logic [31:0] ew, s, m, na, nb;
    @(negedge clk);
    rst = r; clr = c; upd = u; x0 = a0; x1 = a1; x2 = a2;
    ew = (a0 ^ m_a) + m_b;
    s  = m_a + a1;
    m  = m_b ^ a2;
    if (r || c) begin
      na = '0; nb = '0;
    end else if (u) begin
      na = sub32(lin1({s[15:0], m[31:16]}));
      nb = sub32(lin2({m[15:0], s[31:16]}));
    end else begin
      na = m_a; nb = m_b;
    end
    sb_q.push_back({!r, ew, na, nb});
    tag_q.push_back(req);
    m_a = na; m_b = nb;
  endtask

  // monitor
  initial begin
    logic [96:0] it;
    string t;
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        t  = tag_q.pop_front();
        if (it[96]) check({"R1/R8 output before edge, ", t}, {32'h0, w_out}, {32'h0, it[95:64]});
        @(posedge clk);
        #1;
        check(t, {mem_a, mem_b}, it[63:0]);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7 table known answers
    check("R7 T0(0x12)", {56'h0, lut_t0(8'h12)}, 64'hF9);
    check("R7 T1(0x34)", {56'h0, lut_t1(8'h34)}, 64'hC0);
    check("R7 S(0x12345678)", {32'h0, sub32(32'h12345678)}, 64'hF9C05A4E);
    check("R7 S(0)", {32'h0, sub32(32'h0)}, 64'h3E553E55);

    // R6 reset
    drive(1, 0, 0, 0, 0, 0, "R6 reset");
    drive(1, 0, 1, 32'hFFFF_FFFF, 32'h1234, 32'h5678, "R6 reset with update");
    // R7 update from zero: both words S(0)
    drive(0, 0, 1, 32'hA5A5_0000, 0, 0, "R2/R3/R7 update from zero");
    // R2/R3/R8 varied patterns
    for (int i = 0; i < 12; i++) begin
      logic [31:0] p0, p1, p2;
      p0 = rnd(); p1 = rnd(); p2 = rnd();
      drive(0, 0, 1, p0, p1, p2, "R2/R3 update");
    end
    drive(0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2/R3 all-ones inputs");
    // R4 hold with changing inputs
    for (int i = 0; i < 3; i++) begin
      logic [31:0] p0, p1;
      p0 = rnd(); p1 = rnd();
      drive(0, 0, 0, p0, p1, ~p1, "R4 hold");
    end
    // R5 clear wins over update
    drive(0, 1, 1, rnd(), rnd(), rnd(), "R5 clear with update");
    drive(0, 0, 1, rnd(), rnd(), rnd(), "R2/R3 update after clear");
    drive(0, 0, 1, rnd(), rnd(), rnd(), "R2/R3 update");
    drive(0, 1, 0, rnd(), rnd(), rnd(), "R5 clear alone");
    drive(0, 0, 1, rnd(), rnd(), rnd(), "R2/R3 update");
    drive(0, 0, 1, rnd(), rnd(), rnd(), "R2/R3 update");
    // R6 reset mid-run
    drive(1, 0, 1, rnd(), rnd(), rnd(), "R6 reset mid-run");
    drive(0, 0, 0, rnd(), rnd(), rnd(), "R4 hold after reset");

    while (sb_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule